// File: doc/BRIEF.md
# One-Time-Programmable Fuse Array Controller

This block sits on a simple register bus and controls a small fuse array made of banks of 8-bit rows. Inside the block the array is a storage model whose bits can be set but never cleared. Software first loads an upper and a lower address byte. It then writes a command byte to a control register and polls a busy flag in the status register. When busy clears, software checks the done and error flags. A sense command latches the addressed row into a data register, where software reads it.

A program command sets exactly one fuse bit. The command is accepted only while a protect register holds the unlock key. The sequencer keeps the block busy for a parameterised number of cycles for each operation kind. While busy, the block ignores writes to the address and control registers. Status and error flags are write-one-to-clear. An interrupt output reports the status events that are unmasked.

Top module: `fuse_otp_ctrl`

## Requirements
- R1: After reset every register reads 0 and irq_o is 0. The register offsets are:
  - 0: control (reads 0)
  - 1: status
  - 2: interrupt mask
  - 3: error
  - 4: protect
  - 5: upper address
  - 6: lower address
  - 7: sense data
- R2: The fuse address is the 16-bit word {upper, lower}.
  - Bank is bits [15:11], row is bits [10:3] and bit is bits [2:0].
  - The flat fuse index is (bank*NUM_ROWS + row)*8 + bit.
  - An address is in range when bank < NUM_BANKS and row < NUM_ROWS (defaults 4 and 8).
- R3: Writing 0x08 to control starts a sense of an in-range row.
  - Status bit 7 (busy) is high for exactly SENSE_LAT cycles after the write edge.
  - Then status bit 1 (sense done) is set, and the data register holds the row, with data bit n equal to fuse bit n.
- R4: Writing 0x31 to control, while protect holds 0xAA and the address is in range, keeps busy high for exactly PROG_LAT cycles.
  - Then the addressed fuse bit becomes 1 and status bit 0 (program done) is set.
- R5: A program command written while protect is not 0xAA changes no fuse and does not raise busy.
  - Error bit 1 (program error) and status bit 0 are set at the write edge.
- R6: No operation clears a fuse. Programming a bit that is already set leaves it at 1, and the other bits of the row keep their values.
- R7: While busy, writes to the control, upper address and lower address registers have no effect.
- R8: Writing ones to status bits [1:0] clears those bits, and writing ones to error bits [7:1] clears those bits. Zero bits are left unchanged.
- R9: irq_o equals the OR over bits 1:0 of (status AND interrupt mask).
- R10: An out-of-range address raises no busy.
  - A program command sets error bit 1 and status bit 0.
  - A sense command sets error bit 2 and status bit 1, and loads 0 into the data register.
- R11: A control write of any value other than 0x08 or 0x31 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| we_i | input | 1 | Register write strobe for one cycle |
| addr_i | input | 3 | Register offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Combinational read data at addr_i |
| irq_o | output | 1 | Masked status interrupt |

## Verification
The assertions take for granted the following about the bus:
- A write lasts exactly one cycle.
- addr_i and wdata_i are stable while we_i is high.
- No write arrives during reset.

The bench drives every write for one full cycle, from one falling edge to the next, and polls status between operations. The random phase keeps addresses in range, so that the sensed rows can be compared with a bench model. Out-of-range, locked and busy-time writes are exercised only in directed cases.

// File: rtl/fuse_otp_pkg.sv
package fuse_otp_pkg;
  localparam logic [2:0] REG_CTRL  = 3'd0;
  localparam logic [2:0] REG_STAT  = 3'd1;
  localparam logic [2:0] REG_MASK  = 3'd2;
  localparam logic [2:0] REG_ERR   = 3'd3;
  localparam logic [2:0] REG_PROT  = 3'd4;
  localparam logic [2:0] REG_UADDR = 3'd5;
  localparam logic [2:0] REG_LADDR = 3'd6;
  localparam logic [2:0] REG_DATA  = 3'd7;

  localparam logic [7:0] CMD_SENSE  = 8'h08;
  localparam logic [7:0] CMD_PROG   = 8'h31;
  localparam logic [7:0] UNLOCK_KEY = 8'hAA;

  typedef enum logic {OP_SENSE = 1'b0, OP_PROG = 1'b1} op_e;
endpackage

// File: rtl/fuse_seq.sv
module fuse_seq
  import fuse_otp_pkg::*;
#(
  parameter int PROG_LAT  = 64,
  parameter int SENSE_LAT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  op_e  op_i,
  output logic busy_o,
  output logic done_o,
  output op_e  done_op_o
);
  localparam int MAX_LAT = (PROG_LAT > SENSE_LAT) ? PROG_LAT : SENSE_LAT;
  localparam int CNT_W   = (MAX_LAT > 1) ? $clog2(MAX_LAT) : 1;

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  op_e              op_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      op_q   <= OP_SENSE;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        op_q   <= op_i;
        cnt_q  <= (op_i == OP_PROG) ? CNT_W'(PROG_LAT - 1) : CNT_W'(SENSE_LAT - 1);
      end
    end else if (cnt_q == '0) begin
      busy_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy_o    = busy_q;
  assign done_o    = busy_q && (cnt_q == '0);
  assign done_op_o = op_q;

  // Remaining count never exceeds the latency of the running operation
  p_cnt_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (cnt_q <= ((op_q == OP_PROG) ? CNT_W'(PROG_LAT - 1) : CNT_W'(SENSE_LAT - 1))));
  // A start while busy is ignored: the operation kind stays fixed
  p_op_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !done_o) |=> $stable(op_q));
endmodule

// File: rtl/fuse_store.sv
module fuse_store #(
  parameter int NUM_BANKS = 4,
  parameter int NUM_ROWS  = 8,
  localparam int TOTAL_ROWS = NUM_BANKS * NUM_ROWS,
  localparam int NBITS      = TOTAL_ROWS * 8,
  localparam int TROW_W     = (TOTAL_ROWS > 1) ? $clog2(TOTAL_ROWS) : 1,
  localparam int IDX_W      = TROW_W + 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_i,
  input  logic [IDX_W-1:0]  set_idx_i,
  input  logic [TROW_W-1:0] row_idx_i,
  output logic [7:0]        row_o
);
  logic [NBITS-1:0] fuse_q;

  for (genvar g = 0; g < NBITS; g++) begin : g_fuse
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 fuse_q[g] <= 1'b0;
      else if (set_i && (set_idx_i == IDX_W'(g)))  fuse_q[g] <= 1'b1;
    end
  end

  assign row_o = fuse_q[row_idx_i*8 +: 8];

  // A fuse once set stays set
  p_fuse_monotonic_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((fuse_q & $past(fuse_q)) == $past(fuse_q)));
  // Without a set request nothing changes
  p_fuse_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !set_i |=> $stable(fuse_q));
endmodule

// File: rtl/fuse_otp_ctrl.sv
module fuse_otp_ctrl
  import fuse_otp_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int NUM_ROWS  = 8,
  parameter int PROG_LAT  = 64,
  parameter int SENSE_LAT = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [2:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       irq_o
);
  localparam int TOTAL_ROWS = NUM_BANKS * NUM_ROWS;
  localparam int TROW_W     = (TOTAL_ROWS > 1) ? $clog2(TOTAL_ROWS) : 1;

  logic [7:0] uaddr_q, laddr_q, prot_q, data_q;
  logic [1:0] stat_q, mask_q, err_q;  // err_q[0] = error bit1, err_q[1] = error bit2

  logic       busy, seq_done;
  op_e        done_op;
  logic [7:0] row_val;

  // Address decode
  logic [4:0]        bank;
  logic [7:0]        row;
  logic [2:0]        bsel;
  logic              in_range;
  logic [TROW_W-1:0] flat_row;

  assign bank     = uaddr_q[7:3];
  assign row      = {uaddr_q[2:0], laddr_q[7:3]};
  assign bsel     = laddr_q[2:0];
  assign in_range = (32'(bank) < NUM_BANKS) && (32'(row) < NUM_ROWS);
  assign flat_row = TROW_W'(32'(bank) * NUM_ROWS + 32'(row));

  // Command decode
  logic ctrl_wr, cmd_sense, cmd_prog, unlocked, start, prog_rej, sense_rej;
  op_e  start_op;

  assign ctrl_wr   = we_i && (addr_i == REG_CTRL) && !busy;
  assign cmd_sense = ctrl_wr && (wdata_i == CMD_SENSE);
  assign cmd_prog  = ctrl_wr && (wdata_i == CMD_PROG);
  assign unlocked  = (prot_q == UNLOCK_KEY);
  assign start     = (cmd_sense && in_range) || (cmd_prog && in_range && unlocked);
  assign start_op  = cmd_prog ? OP_PROG : OP_SENSE;
  assign prog_rej  = cmd_prog && !(in_range && unlocked);
  assign sense_rej = cmd_sense && !in_range;

  logic prog_fin, sense_fin;
  assign prog_fin  = seq_done && (done_op == OP_PROG);
  assign sense_fin = seq_done && (done_op == OP_SENSE);

  fuse_seq #(.PROG_LAT(PROG_LAT), .SENSE_LAT(SENSE_LAT)) u_seq (
    .clk_i, .rst_ni,
    .start_i(start), .op_i(start_op),
    .busy_o(busy), .done_o(seq_done), .done_op_o(done_op)
  );

  fuse_store #(.NUM_BANKS(NUM_BANKS), .NUM_ROWS(NUM_ROWS)) u_store (
    .clk_i, .rst_ni,
    .set_i(prog_fin), .set_idx_i({flat_row, bsel}),
    .row_idx_i(flat_row), .row_o(row_val)
  );

  logic stat_wr, err_wr;
  assign stat_wr = we_i && (addr_i == REG_STAT);
  assign err_wr  = we_i && (addr_i == REG_ERR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      uaddr_q <= '0;
      laddr_q <= '0;
      prot_q  <= '0;
      data_q  <= '0;
      stat_q  <= '0;
      mask_q  <= '0;
      err_q   <= '0;
    end else begin
      if (we_i && !busy && addr_i == REG_UADDR) uaddr_q <= wdata_i;
      if (we_i && !busy && addr_i == REG_LADDR) laddr_q <= wdata_i;
      if (we_i && addr_i == REG_PROT)           prot_q  <= wdata_i;
      if (we_i && addr_i == REG_MASK)           mask_q  <= wdata_i[1:0];
      if (sense_fin)      data_q <= row_val;
      else if (sense_rej) data_q <= '0;
      // W1C, a new event in the same cycle wins
      stat_q[0] <= (prog_fin || prog_rej) || (stat_q[0] && !(stat_wr && wdata_i[0]));
      stat_q[1] <= (sense_fin || sense_rej) || (stat_q[1] && !(stat_wr && wdata_i[1]));
      err_q[0]  <= prog_rej || (err_q[0] && !(err_wr && wdata_i[1]));
      err_q[1]  <= sense_rej || (err_q[1] && !(err_wr && wdata_i[2]));
    end
  end

  always_comb begin
    unique case (addr_i)
      REG_STAT:  rdata_o = {busy, 5'b0, stat_q};
      REG_MASK:  rdata_o = {6'b0, mask_q};
      REG_ERR:   rdata_o = {5'b0, err_q, 1'b0};
      REG_PROT:  rdata_o = prot_q;
      REG_UADDR: rdata_o = uaddr_q;
      REG_LADDR: rdata_o = laddr_q;
      REG_DATA:  rdata_o = data_q;
      default:   rdata_o = 8'h00;
    endcase
  end

  assign irq_o = |(stat_q & mask_q);

  // Rejected program never starts the sequencer and always reports done
  p_locked_no_busy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == REG_CTRL && wdata_i == CMD_PROG && !busy && prot_q != UNLOCK_KEY)
      |=> (!busy && stat_q[0] && err_q[0]));
  // Address registers frozen while busy
  p_busy_freeze_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |=> ($stable(uaddr_q) && $stable(laddr_q)));
  // End of busy always leaves a done flag behind
  p_done_on_fall_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> (stat_q != 2'b00));
  // Out-of-range sense never raises busy
  p_range_no_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == REG_CTRL && !busy && !in_range) |=> !busy);
endmodule

// File: tb/fuse_otp_ctrl_tb.sv
module fuse_otp_ctrl_tb;
  localparam int NB = 4, NR = 8, PL = 64, SL = 16;
  localparam time TCLK = 20ns;

  logic clk = 1'b0, rst_n = 1'b0, we = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic irq;
  int n_tests = 0, n_fail = 0;
  bit model [NB*NR*8];
  logic [7:0] v;
  int cyc;

  always #(TCLK/2) clk = ~clk;

  fuse_otp_ctrl #(.NUM_BANKS(NB), .NUM_ROWS(NR), .PROG_LAT(PL), .SENSE_LAT(SL)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic set_addr(int b, int r, int bt);
    logic [15:0] a16;
    a16 = 16'((b << 11) | (r << 3) | (bt & 7));
    wr(3'd5, a16[15:8]);
    wr(3'd6, a16[7:0]);
  endtask

  // Cycles busy is seen after a command write
  task automatic busy_cycles(output int n);
    logic [7:0] s;
    n = 0;
    rd(3'd1, s);
    while (s[7] && n < 1000) begin
      @(negedge clk); n++; rd(3'd1, s);
    end
  endtask

  function automatic logic [7:0] model_row(int b, int r);
    logic [7:0] x;
    for (int i = 0; i < 8; i++) x[i] = model[(b*NR + r)*8 + i];
    return x;
  endfunction

  task automatic do_sense(int b, int r, string tag, output logic [7:0] d);
    int n;
    set_addr(b, r, 0);
    wr(3'd0, 8'h08);
    busy_cycles(n);
    check({tag, " sense latency"}, n, SL);
    rd(3'd7, d);
    wr(3'd1, 8'h03);
  endtask

  task automatic do_prog(int b, int r, int bt, string tag);
    int n;
    wr(3'd4, 8'hAA);
    set_addr(b, r, bt);
    wr(3'd0, 8'h31);
    busy_cycles(n);
    check({tag, " prog latency"}, n, PL);
    model[(b*NR + r)*8 + bt] = 1'b1;
    wr(3'd4, 8'h00);
    wr(3'd1, 8'h03);
  endtask

  initial begin
    #(TCLK * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      check("R1 reset reg", v, 0);
    end
    check("R1 reset irq", irq, 0);

    // R3 sense of blank row
    do_sense(0, 0, "R3", v);
    check("R3 blank row", v, 8'h00);

    // R5 locked program
    set_addr(1, 2, 3);
    wr(3'd0, 8'h31);
    rd(3'd1, v);
    check("R5 locked status", v, 8'h01);
    rd(3'd3, v);
    check("R5 locked error", v, 8'h02);
    wr(3'd1, 8'h03);
    wr(3'd3, 8'hFE);
    do_sense(1, 2, "R5", v);
    check("R5 no fuse change", v, 8'h00);

    // R4 program then sense
    do_prog(1, 2, 3, "R4");
    do_sense(1, 2, "R4", v);
    check("R4 row after prog", v, 8'h08);

    // R6 reprogram same bit and a neighbour
    do_prog(1, 2, 3, "R6");
    do_prog(1, 2, 0, "R6");
    do_sense(1, 2, "R6", v);
    check("R6 row keeps bits", v, 8'h09);

    // R2 address formation at the top corner
    do_prog(3, 7, 7, "R2");
    do_sense(3, 7, "R2", v);
    check("R2 top corner row", v, 8'h80);
    do_sense(3, 6, "R2", v);
    check("R2 neighbour row", v, 8'h00);

    // R7 writes ignored while busy
    wr(3'd4, 8'hAA);
    set_addr(2, 1, 5);
    wr(3'd0, 8'h31);
    wr(3'd6, 8'h00);
    wr(3'd5, 8'h08);
    wr(3'd0, 8'h08);
    busy_cycles(cyc);
    check("R7 busy length", cyc, PL - 3);
    model[(2*NR + 1)*8 + 5] = 1'b1;
    rd(3'd6, v);
    check("R7 laddr frozen", v, 8'h0D);
    rd(3'd5, v);
    check("R7 uaddr frozen", v, 8'h10);
    rd(3'd1, v);
    check("R7 no sense done", v, 8'h01);
    wr(3'd4, 8'h00);
    wr(3'd1, 8'h03);
    do_sense(2, 1, "R7", v);
    check("R7 fuse at first address", v, 8'h20);

    // R8 and R9: partial W1C, masking
    set_addr(0, 0, 0);
    wr(3'd0, 8'h31);       // locked: program done + error bit1
    wr(3'd0, 8'h08);       // sense
    busy_cycles(cyc);
    rd(3'd1, v);
    check("R8 both done", v, 8'h03);
    check("R9 irq masked off", irq, 0);
    wr(3'd2, 8'h02);
    check("R9 irq sense unmasked", irq, 1);
    wr(3'd1, 8'h01);
    rd(3'd1, v);
    check("R8 clear bit0 only", v, 8'h02);
    wr(3'd1, 8'h02);
    check("R9 irq after clear", irq, 0);
    rd(3'd3, v);
    check("R8 error held", v, 8'h02);
    wr(3'd3, 8'h04);
    rd(3'd3, v);
    check("R8 error zero bits kept", v, 8'h02);
    wr(3'd3, 8'hFE);
    rd(3'd3, v);
    check("R8 error cleared", v, 8'h00);
    wr(3'd2, 8'h00);

    // R10 out of range
    do_sense(3, 7, "R10 pre", v);  // data reg nonzero
    wr(3'd4, 8'hAA);
    set_addr(NB, 0, 1);
    wr(3'd0, 8'h31);
    rd(3'd1, v);
    check("R10 prog status no busy", v, 8'h01);
    rd(3'd3, v);
    check("R10 prog error", v, 8'h02);
    wr(3'd3, 8'hFE);
    wr(3'd1, 8'h03);
    set_addr(0, NR, 0);
    wr(3'd0, 8'h08);
    rd(3'd1, v);
    check("R10 sense status", v, 8'h02);
    rd(3'd3, v);
    check("R10 sense error", v, 8'h04);
    rd(3'd7, v);
    check("R10 sense data zero", v, 8'h00);
    wr(3'd3, 8'hFE);
    wr(3'd1, 8'h03);

    // R11 unknown command
    set_addr(0, 0, 0);
    wr(3'd0, 8'h55);
    rd(3'd1, v);
    check("R11 unknown cmd status", v, 8'h00);
    wr(3'd4, 8'h00);

    // Random phase: R3 R4 R6 against the model
    for (int i = 0; i < 40; i++) begin
      int b, r, bt;
      b = $urandom_range(NB - 1);
      r = $urandom_range(NR - 1);
      bt = $urandom_range(7);
      if ($urandom_range(1) == 1) do_prog(b, r, bt, "R4 random");
      do_sense(b, r, "R3 random", v);
      check("R6 random row", v, model_row(b, r));
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule